// File: doc/BRIEF.md
# Multi-cycle Multiply/Divide Engine

This block is the multiply and divide execution unit of a small 8-bit processor core. A one-cycle start strobe, together with an operation select and the current contents of the accumulator (A), the index register (X) and the second index register (Y), launches one operation. Multiply forms the full 16-bit product of Y and A. Divide treats Y:A as a 16-bit dividend and X as the divisor. The unit then runs for a fixed number of cycles and returns new A and Y values along with four status flags: negative (N), zero (Z), overflow (V) and half-carry (H).

Divide follows the host core's exact behaviour rather than that of a plain restoring divider. When Y is smaller than twice X, it returns the true quotient (truncated to 8 bits) and the true remainder. Otherwise, which includes X = 0, it returns the core's own overflow formula. Its V and H flags come from comparing the operands. The completion latency is fixed for each operation, so the surrounding pipeline can rely on it. A start that arrives while an operation is in flight has no effect.

Top module: `muldiv_engine`

## Requirements
- R1: Multiply (op_sel = 0) returns the product Y*A with the high byte on y_out and the low byte on a_out.
- R2: After a multiply, flag_n equals bit 7 of y_out and flag_z is 1 exactly when y_out is zero. flag_v and flag_h keep the values they had before the multiply.
- R3: Divide (op_sel = 1) with Y < 2*X returns a_out = low 8 bits of (Y*256+A)/X and y_out = (Y*256+A) mod X.
- R4: Divide with Y >= 2*X, including X = 0, returns a_out = (255 - D/(256-X)) mod 256 and y_out = (X + D mod (256-X)) mod 256, where D = Y*256 + A - 512*X.
- R5: After a divide, flag_v is 1 exactly when Y >= X and flag_h is 1 exactly when Y[3:0] >= X[3:0]. Otherwise both are 0.
- R6: After a divide, flag_n equals bit 7 of a_out and flag_z is 1 exactly when a_out is zero.
- R7: done is a one-cycle pulse. If start is sampled at clock edge 0, done is high in the cycle following edge 9 for a multiply and edge 12 for a divide, and the results are valid in that same cycle.
- R8: A start sampled while an operation is in flight, up to and including the edge on which it completes, is ignored. The running operation's results and timing are unchanged.
- R9: Reset clears a_out, y_out, all four flags and done. Outputs change only on the edge that raises done, and they hold between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, sampled on the rising edge |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | 8 | Accumulator operand (low dividend byte / multiplier) |
| x_in | input | 8 | Divisor |
| y_in | input | 8 | High dividend byte / multiplicand |
| a_out | output | 8 | New accumulator: product low byte or quotient |
| y_out | output | 8 | New Y: product high byte or remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_h | output | 1 | Half-carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the boundary between the two divide paths: Y exactly equal to 2*X - 1 and to 2*X, X = 0, and the case Y = 255, X = 128. A design that picks the wrong path at that boundary, or that lets a 9-bit quotient wrap wrongly, returns the wrong A or Y. Nibble-equal operands catch an H comparison written as strict inequality. A multiply issued after a divide shows whether V and H are wrongly cleared. Another start is injected mid-operation with different operands. A unit that accepted it would corrupt the result or shift the done cycle, so the latency is measured edge by edge for both operations.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;

endpackage

// File: rtl/mdu_seq_ctrl.sv
// Sequencing for the engine: accepts a launch when idle, paces the
// arithmetic steps, and raises done after the fixed latency.
module mdu_seq_ctrl #(
  parameter int W        = 8,
  parameter int MUL_CYC  = 9,
  parameter int DIV_CYC  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_div,
  output logic accept,
  output logic step,
  output logic finish,
  output logic done
);

  localparam int MAX_CYC = (DIV_CYC > MUL_CYC) ? DIV_CYC : MUL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int STEP_W  = $clog2(W + 2);
  localparam logic [CNT_W-1:0]  MUL_LD    = CNT_W'(MUL_CYC - 1);
  localparam logic [CNT_W-1:0]  DIV_LD    = CNT_W'(DIV_CYC - 1);
  localparam logic [STEP_W-1:0] MUL_STEPS = STEP_W'(W);
  localparam logic [STEP_W-1:0] DIV_STEPS = STEP_W'(W + 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  assign accept = start & ~busy_q;
  assign step   = busy_q & (step_q != '0);
  assign finish = busy_q & (cnt_q == '0);
  assign done   = done_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    step_d = step_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = op_div ? DIV_LD : MUL_LD;
      step_d = op_div ? DIV_STEPS : MUL_STEPS;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      if (step_q != '0) begin
        step_d = step_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/mdu_mul_core.sv
// Shift-and-add multiplier: one partial product per step, W steps.
module mdu_mul_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   y_in,
  output logic [2*W-1:0] prod
);

  logic [2*W-1:0] acc_q, acc_d;
  logic [W-1:0]   mcand_q, mcand_d;
  logic [W:0]     upper_sum;

  always_comb begin
    upper_sum = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    acc_d     = acc_q;
    mcand_d   = mcand_q;
    if (load) begin
      acc_d   = {{W{1'b0}}, a_in};
      mcand_d = y_in;
    end else if (step) begin
      acc_d = {upper_sum, acc_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else begin
      acc_q   <= acc_d;
      mcand_q <= mcand_d;
    end
  end

  assign prod = acc_q;

endmodule

// File: rtl/mdu_div_core.sv
// Divider that picks between the true quotient and the core's
// overflow formula at load, then runs one restoring loop of W+1 steps.
module mdu_div_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] a_res,
  output logic [W-1:0] y_res,
  output logic         v_res,
  output logic         h_res
);

  localparam int         NIB  = W / 2;
  localparam logic [W:0] BASE = {1'b1, {W{1'b0}}};

  // load-time operand shaping
  logic [2*W-1:0] ya;
  logic [2*W-1:0] x_scaled;
  logic           ovf_in;
  logic [2*W-1:0] dvd;
  logic [W:0]     dsr;

  // iteration state
  logic [W-1:0] rem_q, rem_d;
  logic [W:0]   low_q, low_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W:0]   dsr_q, dsr_d;
  logic [W-1:0] x_q, x_d;
  logic         ovf_q, ovf_d;
  logic         v_q, v_d;
  logic         h_q, h_d;

  logic [W:0]   trial;
  logic         fits;

  always_comb begin
    ya       = {y_in, a_in};
    x_scaled = {x_in[W-2:0], {(W+1){1'b0}}};
    ovf_in   = ({1'b0, y_in} >= {x_in, 1'b0});
    dvd      = ovf_in ? (ya - x_scaled) : ya;
    dsr      = ovf_in ? (BASE - {1'b0, x_in}) : {1'b0, x_in};
  end

  always_comb begin
    trial = {rem_q, low_q[W]};
    fits  = (trial >= dsr_q);
    rem_d = rem_q;
    low_d = low_q;
    quo_d = quo_q;
    dsr_d = dsr_q;
    x_d   = x_q;
    ovf_d = ovf_q;
    v_d   = v_q;
    h_d   = h_q;
    if (load) begin
      rem_d = {1'b0, dvd[2*W-1:W+1]};
      low_d = dvd[W:0];
      quo_d = '0;
      dsr_d = dsr;
      x_d   = x_in;
      ovf_d = ovf_in;
      v_d   = (y_in >= x_in);
      h_d   = (y_in[NIB-1:0] >= x_in[NIB-1:0]);
    end else if (step) begin
      rem_d = fits ? (trial[W-1:0] - dsr_q[W-1:0]) : trial[W-1:0];
      low_d = {low_q[W-1:0], 1'b0};
      quo_d = {quo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      low_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      x_q   <= '0;
      ovf_q <= 1'b0;
      v_q   <= 1'b0;
      h_q   <= 1'b0;
    end else begin
      rem_q <= rem_d;
      low_q <= low_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
      x_q   <= x_d;
      ovf_q <= ovf_d;
      v_q   <= v_d;
      h_q   <= h_d;
    end
  end

  assign a_res = ovf_q ? ~quo_q : quo_q;
  assign y_res = ovf_q ? (x_q + rem_q) : rem_q;
  assign v_res = v_q;
  assign h_res = h_q;

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
  parameter int W       = 8,
  parameter int MUL_CYC = 9,
  parameter int DIV_CYC = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] y_out,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_h,
  output logic         done
);

  import mdu_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic    accept, step, finish;
  mdu_op_e op_q, op_d;

  mdu_seq_ctrl #(.W(W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start),
    .op_div (op_sel),
    .accept (accept),
    .step   (step),
    .finish (finish),
    .done   (done)
  );

  logic [2*W-1:0] prod;
  logic           mul_load, div_load;

  assign mul_load = accept & (mdu_op_e'(op_sel) == OP_MUL);
  assign div_load = accept & (mdu_op_e'(op_sel) == OP_DIV);

  mdu_mul_core #(.W(W)) i_mul (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (mul_load),
    .step  (step & (op_q == OP_MUL)),
    .a_in  (a_in),
    .y_in  (y_in),
    .prod  (prod)
  );

  logic [W-1:0] div_a, div_y;
  logic         div_v, div_h;

  mdu_div_core #(.W(W)) i_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (div_load),
    .step  (step & (op_q == OP_DIV)),
    .a_in  (a_in),
    .x_in  (x_in),
    .y_in  (y_in),
    .a_res (div_a),
    .y_res (div_y),
    .v_res (div_v),
    .h_res (div_h)
  );

  // result registers
  logic [W-1:0] a_q, a_d, y_q, y_d;
  logic         n_q, n_d, z_q, z_d, v_q, v_d, h_q, h_d;

  always_comb begin
    op_d = accept ? mdu_op_e'(op_sel) : op_q;
    a_d  = a_q;
    y_d  = y_q;
    n_d  = n_q;
    z_d  = z_q;
    v_d  = v_q;
    h_d  = h_q;
    if (finish) begin
      if (op_q == OP_DIV) begin
        a_d = div_a;
        y_d = div_y;
        n_d = div_a[W-1];
        z_d = (div_a == '0);
        v_d = div_v;
        h_d = div_h;
      end else begin
        a_d = prod[W-1:0];
        y_d = prod[2*W-1:W];
        n_d = prod[2*W-1];
        z_d = (prod[2*W-1:W] == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q <= OP_MUL;
      a_q  <= '0;
      y_q  <= '0;
      n_q  <= 1'b0;
      z_q  <= 1'b0;
      v_q  <= 1'b0;
      h_q  <= 1'b0;
    end else begin
      op_q <= op_d;
      a_q  <= a_d;
      y_q  <= y_d;
      n_q  <= n_d;
      z_q  <= z_d;
      v_q  <= v_d;
      h_q  <= h_d;
    end
  end

  assign a_out  = a_q;
  assign y_out  = y_q;
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_v = v_q;
  assign flag_h = h_q;

endmodule

// File: rtl/mdu_chk.sv
// Port-level checker for muldiv_engine, attached through bind.
module mdu_chk #(
  parameter int W       = 8,
  parameter int MUL_CYC = 9,
  parameter int DIV_CYC = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         op_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] x_in,
  input logic [W-1:0] y_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] y_out,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_v,
  input logic         flag_h,
  input logic         done
);

  localparam int NIB = W / 2;

  logic           m_busy;
  logic [7:0]     m_cnt;
  logic           m_op;
  logic [W-1:0]   m_a, m_x, m_y;
  logic [7:0]     m_lat;
  logic           m_due;
  logic [2*W-1:0] m_prod;

  assign m_lat  = m_op ? 8'(DIV_CYC) : 8'(MUL_CYC);
  assign m_due  = m_busy && (m_cnt == m_lat);
  assign m_prod = {{W{1'b0}}, m_y} * {{W{1'b0}}, m_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      m_cnt  <= '0;
      m_op   <= 1'b0;
      m_a    <= '0;
      m_x    <= '0;
      m_y    <= '0;
    end else if (start && (!m_busy || m_due)) begin
      m_busy <= 1'b1;
      m_cnt  <= '0;
      m_op   <= op_sel;
      m_a    <= a_in;
      m_x    <= x_in;
      m_y    <= y_in;
    end else if (m_due) begin
      m_busy <= 1'b0;
    end else if (m_busy) begin
      m_cnt <= m_cnt + 1'b1;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> m_due);

  // R8
  done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_due |-> done);

  // R1
  mul_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m_op) |-> ({y_out, a_out} == m_prod));

  // R5
  div_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_op) |-> ((flag_v == (m_y >= m_x)) &&
                        (flag_h == (m_y[NIB-1:0] >= m_x[NIB-1:0]))));

  // R2
  mul_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m_op) |-> ((flag_n == y_out[W-1]) && (flag_z == (y_out == '0))));

  // R6
  div_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_op) |-> ((flag_n == a_out[W-1]) && (flag_z == (a_out == '0))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_out) && $stable(y_out) && $stable(flag_n) &&
               $stable(flag_z) && $stable(flag_v) && $stable(flag_h)));

endmodule

bind muldiv_engine mdu_chk #(.W(W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) i_mdu_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .op_sel (op_sel),
  .a_in   (a_in),
  .x_in   (x_in),
  .y_in   (y_in),
  .a_out  (a_out),
  .y_out  (y_out),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v),
  .flag_h (flag_h),
  .done   (done)
);

// File: tb/test_muldiv_engine.sv
module test_muldiv_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       op_sel;
  logic [7:0] a_in, x_in, y_in;
  logic [7:0] a_out, y_out;
  logic       flag_n, flag_z, flag_v, flag_h, done;

  int n_chk  = 0;
  int n_fail = 0;
  logic exp_v = 1'b0;
  logic exp_h = 1'b0;

  always #10 clk = ~clk;

  muldiv_engine i_muldiv_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .a_in(a_in), .x_in(x_in), .y_in(y_in),
    .a_out(a_out), .y_out(y_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_h(flag_h),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_div(input int a, input int x, input int y,
                                  output logic [7:0] qa, output logic [7:0] ry);
    int ya, t, d;
    ya = y * 256 + a;
    if (y < 2 * x) begin
      qa = 8'((ya / x) & 255);
      ry = 8'(ya % x);
    end else begin
      t  = ya - 512 * x;
      d  = 256 - x;
      qa = 8'((255 - t / d) & 255);
      ry = 8'((x + t % d) & 255);
    end
  endfunction

  task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] y, input bit inject);
    logic [7:0] ea, ey;
    logic       en, ez;
    int         lat, k;
    bit         got;
    string      tag_r;
    if (op) begin
      ref_div(int'(a), int'(x), int'(y), ea, ey);
      exp_v = (y >= x);
      exp_h = (y[3:0] >= x[3:0]);
      en    = ea[7];
      ez    = (ea == 8'd0);
      lat   = 12;
      tag_r = (int'(y) < 2 * int'(x)) ? "R3" : "R4";
    end else begin
      {ey, ea} = 16'(int'(y) * int'(a));
      en    = ey[7];
      ez    = (ey == 8'd0);
      lat   = 9;
      tag_r = "R1";
    end
    if (inject) tag_r = "R8";
    @(negedge clk);
    start = 1'b1; op_sel = op; a_in = a; x_in = x; y_in = y;
    @(negedge clk);
    start = 1'b0;
    k = 0; got = 0;
    while (!got && k < 40) begin
      @(negedge clk);
      k++;
      if (inject && k == 3) begin
        start = 1'b1; op_sel = ~op; a_in = ~a; x_in = x + 8'd7; y_in = ~y;
      end else begin
        start = 1'b0;
      end
      got = done;
    end
    // R7 latency measured in edges after the start edge
    chk(k == lat, inject ? "R8 latency" : "R7 latency", k, lat);
    chk(a_out == ea, {tag_r, " a_out"}, int'(a_out), int'(ea));
    chk(y_out == ey, {tag_r, " y_out"}, int'(y_out), int'(ey));
    chk(flag_n == en, op ? "R6 flag_n" : "R2 flag_n", int'(flag_n), int'(en));
    chk(flag_z == ez, op ? "R6 flag_z" : "R2 flag_z", int'(flag_z), int'(ez));
    chk(flag_v == exp_v, op ? "R5 flag_v" : "R2 flag_v kept", int'(flag_v), int'(exp_v));
    chk(flag_h == exp_h, op ? "R5 flag_h" : "R2 flag_h kept", int'(flag_h), int'(exp_h));
    @(negedge clk);
    // R7 single-cycle pulse, R9 hold
    chk(done == 1'b0, "R7 pulse", int'(done), 0);
    chk(a_out == ea && y_out == ey, "R9 hold", int'({y_out, a_out}), int'({ey, ea}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] ra, rx, ry;
    logic       rop;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; op_sel = 1'b0;
    a_in = '0; x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(a_out == 0 && y_out == 0, "R9 reset data", int'({y_out, a_out}), 0);
    chk({flag_n, flag_z, flag_v, flag_h, done} == 5'b0, "R9 reset flags",
        int'({flag_n, flag_z, flag_v, flag_h, done}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_op(1'b0, 8'd0,   8'd0,   8'd0,   0);
    run_op(1'b0, 8'd255, 8'd0,   8'd255, 0);
    run_op(1'b1, 8'h34,  8'h12,  8'h12,  0); // V and H set, nibble equal
    run_op(1'b0, 8'd16,  8'd3,   8'd16,  0); // R2 V/H kept from divide
    run_op(1'b1, 8'd77,  8'd0,   8'd5,   0); // divisor zero
    run_op(1'b1, 8'd255, 8'd128, 8'd255, 0); // 9-bit quotient
    run_op(1'b1, 8'd200, 8'd40,  8'd79,  0); // Y = 2X-1
    run_op(1'b1, 8'd200, 8'd40,  8'd80,  0); // Y = 2X
    run_op(1'b1, 8'd0,   8'd1,   8'd0,   0); // zero quotient
    run_op(1'b1, 8'd9,   8'd27,  8'd3,   0); // H clear, V clear
    run_op(1'b1, 8'd0,   8'd127, 8'd255, 0);
    run_op(1'b0, 8'd12,  8'd0,   8'd34,  1); // busy start ignored
    run_op(1'b1, 8'd99,  8'd50,  8'd20,  1);

    for (int i = 0; i < 300; i++) begin
      rop = 1'($urandom);
      ra  = 8'($urandom);
      ry  = 8'($urandom);
      rx  = (($urandom % 4) == 0) ? 8'($urandom % 16) : 8'($urandom);
      run_op(rop, ra, rx, ry, (($urandom % 16) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule